// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit logical address into a real page address by walking a hierarchy of up to five in-memory tables: three region levels, a segment level and a page level. A request carries the address, the access kind (read, store or instruction fetch) and the address-space mode. The mode selects which control-register designation starts the walk. The designation's type field chooses the level where the walk begins, so a walk can start at any of the four upper levels.

The walker reads each 64-bit table entry through a single-outstanding memory read port. At every level it checks the entry's invalid bit, its type field and the index window. It gathers protection along the way. A segment entry can end the walk early with a 1 MB frame when large frames are enabled. The walk ends with a one-cycle `done` pulse. The result is either a real page address with read, write and execute permissions, or a fault code together with an exception word.

Translation caching, access-register mode and the prefix stage that follows are outside this block.

Top module: `xlate_walker`

## Requirements
- R1: When `datEnable` is low, the result is the request address with bits 11:0 cleared, all three permissions are granted, no fault is raised and no memory read is issued.
- R2: Designation selection works as follows. Mode 2'b00 and 2'b01 use `cr1`, and mode 2'b11 uses `cr13`. In mode 2'b10 (secondary), an instruction fetch (kind 2'b10) uses `cr1` and keeps only execute permission. Any other access in secondary mode uses `cr7` and keeps only read and write permission. Kind 2'b01 is a store, and kinds 2'b00 and 2'b11 are reads.
- R3: When bit 5 of the selected designation is set, the result is the page address unchanged, with no fault and no memory read. The permissions are those of R2 for the mode.
- R4: Designation bits 3:2 give the start level: 3 for region-first, 2 for region-second, 1 for region-third, 0 for segment. Starting at region-second, region-third or segment requires logical bits 63:53, 63:42 or 63:31 respectively to be zero. Otherwise the walk ends with fault code 0x38.
- R5: The top two bits of the first index (bits 63:62, 52:51, 41:40 or 30:29) are compared with designation bits 1:0. If the index bits exceed that value, the walk ends with the start level's translation fault. The codes are 0x39 for region-first, 0x3A for region-second, 0x3B for region-third and 0x10 for segment.
- R6: The index fields are logical bits 63:53, 52:42, 41:31 and 30:20 for region-first, region-second, region-third and segment. Each entry is read at 8 times the index, added to the origin in bits 63:12 of the designation or region entry. Page entries are read at the segment entry's bits 63:11 plus 8 times logical bits 19:12.
- R7: A region or segment entry with bit 5 set raises that level's translation fault. Otherwise, an entry whose bits 3:2 differ from the level's type code (3, 2, 1, 0) raises specification fault 0x12.
- R8: A region entry passes only if the top two bits of the next level's index lie between entry bits 7:6 and entry bits 1:0, inclusive. Otherwise the next level's translation fault is raised.
- R9: With `largeEn` high, a segment entry with bit 10 set ends the walk with entry bits 63:20 joined to logical bits 19:12. With `largeEn` low, that bit has no effect and the walk continues to the page table.
- R10: A page entry with bit 10 set raises fault 0x11. Otherwise, bit 8 set raises 0x12. Otherwise the result is entry bits 63:12.
- R11: Bit 9 removes write permission in a segment entry and in a page entry. In a region entry it does so only when `largeEn` is high. A store that completes a walk without write permission ends with fault 0x04.
- R12: On a fault, `excWord` is the page address ORed with 0x400 for a store or 0x800 otherwise, plus the mode bits in bits 1:0. A secondary-mode fetch uses mode bits 2'b00. A protection fault also sets bit 2. On success, `excWord` is zero.
- R13: `reqReady` is high only while idle. `memReqValid` and `done` are single-cycle pulses. A fault returns zero address and no permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken while `reqReady`) |
| reqReady | output | 1 | Walker idle |
| reqAddr | input | 64 | Logical address |
| reqKind | input | 2 | 00 read, 01 store, 10 fetch |
| reqMode | input | 2 | Address-space mode |
| datEnable | input | 1 | Translation on |
| largeEn | input | 1 | Large frames enabled |
| cr1 | input | 64 | Primary designation |
| cr7 | input | 64 | Secondary designation |
| cr13 | input | 64 | Home designation |
| memReqValid | output | 1 | Entry read request pulse |
| memReqAddr | output | 64 | Entry address |
| memRspValid | input | 1 | Entry data valid |
| memRspData | input | 64 | Entry data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 8 | Fault code |
| excWord | output | 64 | Translation exception word |
| resAddr | output | 64 | Real page address |
| permR | output | 1 | Read allowed |
| permW | output | 1 | Write allowed |
| permX | output | 1 | Execute allowed |

## Verification
The assertions assume the memory port delivers exactly one `memRspValid` pulse per request, and only while the walker is waiting for it. They also assume the request inputs and control registers are sampled only at the accepting edge. The bench memory model answers each request once, two cycles later. Unmapped addresses return an entry with both invalid positions set. Requests are only raised while `reqReady` is high, and designations are changed only between walks, so every property sees the input discipline it relies on.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int AddrW    = 64;
  localparam int PageBits = 12;
  localparam int IdxW     = 11;
  localparam int PxW      = 8;
  localparam int EntBytes = 3;
  localparam int CodeW    = 8;

  typedef enum logic [2:0] {
    LV_R1   = 3'd0,
    LV_R2   = 3'd1,
    LV_R3   = 3'd2,
    LV_SEG  = 3'd3,
    LV_PAGE = 3'd4
  } level_e;

  typedef enum logic [1:0] {STEP_FETCH, STEP_OK, STEP_FAULT} step_e;

  typedef struct packed {
    logic capture;
    logic evalPhase;
    logic takeEntry;
    logic advance;
    logic finish;
  } strobe_t;

  localparam logic [1:0] KIND_STORE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;
  localparam logic [1:0] MODE_SEC   = 2'b10;
  localparam logic [1:0] MODE_HOME  = 2'b11;

  localparam logic [CodeW-1:0] FC_NONE  = 8'h00;
  localparam logic [CodeW-1:0] FC_PROT  = 8'h04;
  localparam logic [CodeW-1:0] FC_SEG   = 8'h10;
  localparam logic [CodeW-1:0] FC_PAGE  = 8'h11;
  localparam logic [CodeW-1:0] FC_SPEC  = 8'h12;
  localparam logic [CodeW-1:0] FC_DTYPE = 8'h38;
  localparam logic [CodeW-1:0] FC_R1    = 8'h39;
  localparam logic [CodeW-1:0] FC_R2    = 8'h3A;
  localparam logic [CodeW-1:0] FC_R3    = 8'h3B;

  function automatic logic [CodeW-1:0] xlCode(level_e lv);
    case (lv)
      LV_R1:   xlCode = FC_R1;
      LV_R2:   xlCode = FC_R2;
      LV_R3:   xlCode = FC_R3;
      LV_SEG:  xlCode = FC_SEG;
      default: xlCode = FC_PAGE;
    endcase
  endfunction

  function automatic logic [IdxW-1:0] idxOf(level_e lv, logic [AddrW-1:0] va);
    case (lv)
      LV_R1:   idxOf = va[63:53];
      LV_R2:   idxOf = va[52:42];
      LV_R3:   idxOf = va[41:31];
      default: idxOf = va[30:20];
    endcase
  endfunction
endpackage

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memRspValid,
  input  step_e   stepKind,
  output strobe_t strb,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT, S_EVAL, S_DONE} state_e;

  state_e state, stateNext;
  logic deciding;

  assign deciding = (state == S_CHECK) || (state == S_EVAL);

  always_comb begin
    strb           = '0;
    strb.capture   = (state == S_IDLE) && reqValid;
    strb.evalPhase = (state == S_EVAL);
    strb.takeEntry = (state == S_WAIT) && memRspValid;
    strb.advance   = deciding && (stepKind == STEP_FETCH);
    strb.finish    = deciding && (stepKind != STEP_FETCH);
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:          if (reqValid) stateNext = S_CHECK;
      S_CHECK, S_EVAL: stateNext = (stepKind == STEP_FETCH) ? S_ISSUE : S_DONE;
      S_ISSUE:         stateNext = S_WAIT;
      S_WAIT:          if (memRspValid) stateNext = S_EVAL;
      S_DONE:          stateNext = S_IDLE;
      default:         stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign done        = (state == S_DONE);

  // R13: one read request per table level
  a_r13_req_single: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R13: result strobe lasts one cycle
  a_r13_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R13: memory answers only an outstanding read
  a_r13_rsp_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (state == S_WAIT));
endmodule

// File: rtl/xw_dpath.sv
module xw_dpath
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [1:0]       reqKind,
  input  logic [1:0]       reqMode,
  input  logic             datEnable,
  input  logic             largeEn,
  input  logic [AddrW-1:0] cr1,
  input  logic [AddrW-1:0] cr7,
  input  logic [AddrW-1:0] cr13,
  input  logic [AddrW-1:0] memRspData,
  output step_e            stepKind,
  output logic [AddrW-1:0] memReqAddr,
  output logic [AddrW-1:0] resAddr,
  output logic             permR,
  output logic             permW,
  output logic             permX,
  output logic             fault,
  output logic [CodeW-1:0] faultCode,
  output logic [AddrW-1:0] excWord
);
  logic [AddrW-1:0] vaQ, desigQ, entryQ, fetchQ, selDesig;
  logic [1:0]       kindQ, modeQ;
  logic             datQ, largeQ, wQ;
  level_e           levelQ;

  logic [CodeW-1:0] stepCode;
  level_e           nextLevel, lvNext;
  logic [AddrW-1:0] nextFetch, okAddr;
  logic             newW;
  logic [IdxW-1:0]  idxCur, idxNext;
  logic             hiBad;

  logic isStore, isFetch, secMode, maskR, maskW, maskX;
  logic [1:0] effMode;

  always_comb begin
    if (reqMode == MODE_HOME)                            selDesig = cr13;
    else if (reqMode == MODE_SEC && reqKind != KIND_FETCH) selDesig = cr7;
    else                                                 selDesig = cr1;
  end

  assign isStore = (kindQ == KIND_STORE);
  assign isFetch = (kindQ == KIND_FETCH);
  assign secMode = (modeQ == MODE_SEC);
  assign effMode = (secMode && isFetch) ? 2'b00 : modeQ;
  assign maskR   = !(secMode && isFetch);
  assign maskW   = !(secMode && isFetch);
  assign maskX   = !(secMode && !isFetch);

  always_comb begin
    stepKind  = STEP_FETCH;
    stepCode  = FC_NONE;
    nextLevel = levelQ;
    nextFetch = '0;
    okAddr    = '0;
    newW      = wQ;
    lvNext    = levelQ;
    idxCur    = '0;
    idxNext   = '0;
    hiBad     = 1'b0;
    if (!strb.evalPhase) begin
      nextLevel = level_e'({1'b0, ~desigQ[3:2]});
      idxCur    = idxOf(nextLevel, vaQ);
      case (nextLevel)
        LV_R2:   hiBad = |vaQ[63:53];
        LV_R3:   hiBad = |vaQ[63:42];
        LV_SEG:  hiBad = |vaQ[63:31];
        default: hiBad = 1'b0;
      endcase
      if (!datQ || desigQ[5]) begin
        stepKind = STEP_OK;
        okAddr   = vaQ;
      end else if (hiBad) begin
        stepKind = STEP_FAULT;
        stepCode = FC_DTYPE;
      end else if (idxCur[IdxW-1 -: 2] > desigQ[1:0]) begin
        stepKind = STEP_FAULT;
        stepCode = xlCode(nextLevel);
      end else begin
        nextFetch = {desigQ[63:PageBits], {PageBits{1'b0}}}
                  + {{(AddrW-IdxW-EntBytes){1'b0}}, idxCur, {EntBytes{1'b0}}};
      end
    end else if (levelQ == LV_PAGE) begin
      if (entryQ[10]) begin
        stepKind = STEP_FAULT;
        stepCode = FC_PAGE;
      end else if (entryQ[8]) begin
        stepKind = STEP_FAULT;
        stepCode = FC_SPEC;
      end else begin
        newW     = wQ & ~entryQ[9];
        stepKind = STEP_OK;
        okAddr   = {entryQ[63:PageBits], {PageBits{1'b0}}};
      end
    end else if (entryQ[5]) begin
      stepKind = STEP_FAULT;
      stepCode = xlCode(levelQ);
    end else if (entryQ[3:2] != ~levelQ[1:0]) begin
      stepKind = STEP_FAULT;
      stepCode = FC_SPEC;
    end else if (levelQ == LV_SEG) begin
      newW = wQ & ~entryQ[9];
      if (largeQ && entryQ[10]) begin
        stepKind = STEP_OK;
        okAddr   = {entryQ[63:20], vaQ[19:PageBits], {PageBits{1'b0}}};
      end else begin
        nextLevel = LV_PAGE;
        nextFetch = {entryQ[63:11], 11'b0}
                  + {{(AddrW-PxW-EntBytes){1'b0}}, vaQ[19:PageBits], {EntBytes{1'b0}}};
      end
    end else begin
      lvNext  = level_e'(levelQ + 3'd1);
      idxNext = idxOf(lvNext, vaQ);
      if (idxNext[IdxW-1 -: 2] < entryQ[7:6] || idxNext[IdxW-1 -: 2] > entryQ[1:0]) begin
        stepKind = STEP_FAULT;
        stepCode = xlCode(lvNext);
      end else begin
        if (largeQ && entryQ[9]) newW = 1'b0;
        nextLevel = lvNext;
        nextFetch = {entryQ[63:PageBits], {PageBits{1'b0}}}
                  + {{(AddrW-IdxW-EntBytes){1'b0}}, idxNext, {EntBytes{1'b0}}};
      end
    end
    if (strb.evalPhase && stepKind == STEP_OK && isStore && !newW) begin
      stepKind = STEP_FAULT;
      stepCode = FC_PROT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; desigQ <= '0; entryQ <= '0; fetchQ <= '0;
      kindQ <= '0; modeQ <= '0; datQ <= 1'b0; largeQ <= 1'b0; wQ <= 1'b1;
      levelQ <= LV_R1;
      resAddr <= '0; permR <= 1'b0; permW <= 1'b0; permX <= 1'b0;
      fault <= 1'b0; faultCode <= FC_NONE; excWord <= '0;
    end else begin
      if (strb.capture) begin
        vaQ    <= {reqAddr[AddrW-1:PageBits], {PageBits{1'b0}}};
        kindQ  <= reqKind;
        modeQ  <= reqMode;
        desigQ <= selDesig;
        datQ   <= datEnable;
        largeQ <= largeEn;
        wQ     <= 1'b1;
      end
      if (strb.takeEntry) entryQ <= memRspData;
      if (strb.advance) begin
        levelQ <= nextLevel;
        fetchQ <= nextFetch;
        wQ     <= newW;
      end
      if (strb.finish) begin
        if (stepKind == STEP_OK) begin
          resAddr   <= okAddr;
          permR     <= datQ ? maskR : 1'b1;
          permW     <= newW & (datQ ? maskW : 1'b1);
          permX     <= datQ ? maskX : 1'b1;
          fault     <= 1'b0;
          faultCode <= FC_NONE;
          excWord   <= '0;
        end else begin
          resAddr   <= '0;
          permR     <= 1'b0;
          permW     <= 1'b0;
          permX     <= 1'b0;
          fault     <= 1'b1;
          faultCode <= stepCode;
          excWord   <= vaQ | (isStore ? 64'h400 : 64'h800)
                     | {{(AddrW-2){1'b0}}, effMode}
                     | ((stepCode == FC_PROT) ? 64'h4 : 64'h0);
        end
      end
    end
  end

  assign memReqAddr = fetchQ;

  logic unusedDp;
  assign unusedDp = ^{reqAddr[PageBits-1:0], desigQ[11:6], desigQ[4], entryQ[4]};

  // R1/R3: no table read once translation is off or the space is real
  a_r1_no_walk_when_direct: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (datQ && !desigQ[5]));
  // R6: entry addresses are 8-byte aligned
  a_r6_entry_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (memReqAddr[2:0] == 3'b000));
  // R12: protection word carries store and protection marks
  a_r12_prot_word: assert property (@(posedge clk) disable iff (!rstN)
    (fault && faultCode == FC_PROT) |-> (excWord[2] && excWord[10]));
  // R2: secondary fetch ends without data permissions
  a_r2_sec_fetch_masks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && stepKind == STEP_OK && datQ && secMode && isFetch)
      |=> (!permR && !permW && permX));
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [63:0] reqAddr,
  input  logic [1:0]  reqKind,
  input  logic [1:0]  reqMode,
  input  logic        datEnable,
  input  logic        largeEn,
  input  logic [63:0] cr1,
  input  logic [63:0] cr7,
  input  logic [63:0] cr13,
  output logic        memReqValid,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        done,
  output logic        fault,
  output logic [7:0]  faultCode,
  output logic [63:0] excWord,
  output logic [63:0] resAddr,
  output logic        permR,
  output logic        permW,
  output logic        permX
);
  strobe_t strb;
  step_e   stepKind;

  xw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .stepKind(stepKind), .strb(strb), .reqReady(reqReady),
    .memReqValid(memReqValid), .done(done)
  );

  xw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqMode(reqMode), .datEnable(datEnable), .largeEn(largeEn),
    .cr1(cr1), .cr7(cr7), .cr13(cr13), .memRspData(memRspData),
    .stepKind(stepKind), .memReqAddr(memReqAddr), .resAddr(resAddr),
    .permR(permR), .permW(permW), .permX(permX), .fault(fault),
    .faultCode(faultCode), .excWord(excWord)
  );
endmodule

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
  localparam time ClkPeriod = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [63:0] reqAddr = '0;
  logic [1:0] reqKind = '0, reqMode = '0;
  logic datEnable = 1'b1, largeEn = 1'b0;
  logic [63:0] cr1 = '0, cr7 = '0, cr13 = '0;
  logic memReqValid, memRspValid = 1'b0;
  logic [63:0] memReqAddr, memRspData = '0;
  logic done, fault, permR, permW, permX;
  logic [7:0] faultCode;
  logic [63:0] excWord, resAddr;

  int nChecks = 0, nFails = 0, reqCount = 0, cycles = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] pendAddr = '0;
  logic [1:0] pendCnt = '0;

  always #(ClkPeriod/2) clk = ~clk;

  xlate_walker u_xlate_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqKind(reqKind), .reqMode(reqMode),
    .datEnable(datEnable), .largeEn(largeEn), .cr1(cr1), .cr7(cr7), .cr13(cr13),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .fault(fault), .faultCode(faultCode), .excWord(excWord), .resAddr(resAddr),
    .permR(permR), .permW(permW), .permX(permX)
  );

  function automatic logic [63:0] rd(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h420;
  endfunction

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid) begin
      pendAddr <= memReqAddr;
      pendCnt  <= 2'd2;
      reqCount <= reqCount + 1;
    end else if (pendCnt != 0) begin
      pendCnt <= pendCnt - 2'd1;
      if (pendCnt == 2'd1) begin
        memRspValid <= 1'b1;
        memRspData  <= rd(pendAddr);
      end
    end
  end

  function automatic logic [63:0] xw(logic [63:0] va, logic [1:0] kind,
                                     logic [1:0] mb, logic prot);
    return {va[63:12], 12'h0} | ((kind == 2'b01) ? 64'h400 : 64'h800)
         | {62'b0, mb} | (prot ? 64'h4 : 64'h0);
  endfunction

  task automatic fail(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
    nFails++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
  endtask

  task automatic walk(input logic [63:0] va, input logic [1:0] kind,
                      input logic [1:0] mode);
    int waitCnt;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = va; reqKind = kind; reqMode = mode; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      nChecks++;
      fail("R13", "walk timeout", 64'(waitCnt), 64'd200);
    end
  endtask

  task automatic expectOk(input string tag, input logic [63:0] addr,
                          input logic [2:0] rwx);
    nChecks++;
    if (fault !== 1'b0 || resAddr !== addr || {permR, permW, permX} !== rwx
        || excWord !== 64'h0)
      fail(tag, "addr/fault/rwx/word",
           {resAddr[59:0], fault, permR, permW, permX},
           {addr[59:0], 1'b0, rwx});
  endtask

  task automatic expectFault(input string tag, input logic [7:0] code,
                             input logic [63:0] word);
    nChecks++;
    if (fault !== 1'b1 || faultCode !== code || excWord !== word
        || resAddr !== 64'h0 || {permR, permW, permX} !== 3'b000)
      fail(tag, "code/word", {faultCode, excWord[55:0]}, {code, word[55:0]});
  endtask

  task automatic expectVal(input string tag, input logic [63:0] got,
                           input logic [63:0] exp);
    nChecks++;
    if (got !== exp) fail(tag, "value", got, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++;
        fail("R13", "watchdog", 64'(cycles), 64'd150000);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] va;
    // table image: region-first chain to a segment table at 0x40000
    mem[64'h10000] = 64'h2000F;
    mem[64'h20000] = 64'h3000B;
    mem[64'h30000] = 64'h40007;
    mem[64'h40000] = 64'h50000;
    mem[64'h40008] = 64'hA00400;
    mem[64'h40010] = 64'h50A00;
    mem[64'h40018] = 64'h20;
    mem[64'h40020] = 64'h50004;
    mem[64'h41000] = 64'h50000;
    mem[64'h50800] = 64'h7000_0000;
    mem[64'h60000] = 64'h40207;
    mem[64'h60008] = 64'h40046;
    for (int p = 0; p < 16; p++) begin
      logic [63:0] fr;
      fr = 64'h8000_0000 + (64'(p) << 12);
      if (p == 5)      mem[64'h50000 + 64'(p*8)] = 64'h400;
      else if (p == 7) mem[64'h50000 + 64'(p*8)] = fr | 64'h100;
      else if (p == 9) mem[64'h50000 + 64'(p*8)] = fr | 64'h200;
      else             mem[64'h50000 + 64'(p*8)] = fr;
    end
    cr1 = 64'h1000F; cr7 = 64'h40000; cr13 = 64'h60004;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: idle after reset
    expectVal("R13 reset", {61'b0, reqReady, done, memReqValid}, 64'b100);

    // R1: translation off
    datEnable = 1'b0; reqCount = 0;
    walk(64'h1234_5678_9ABC, 2'b01, 2'b10);
    expectOk("R1 dat off", 64'h1234_5678_9000, 3'b111);
    expectVal("R1 no reads", 64'(reqCount), 64'd0);
    datEnable = 1'b1;

    // R3: real-space designation
    cr13 = 64'h20; reqCount = 0;
    walk(64'hFFFF_0000_1234_5FFF, 2'b01, 2'b11);
    expectOk("R3 real space", 64'hFFFF_0000_1234_5000, 3'b111);
    expectVal("R3 no reads", 64'(reqCount), 64'd0);
    cr13 = 64'h60004;

    // R10/R11/R12/R6: page sweep through all four upper levels
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 3; k++) begin
        va = (64'(p) << 12) | 64'hABC;
        walk(va, 2'(k), 2'b00);
        if (p == 5)      expectFault("R10 invalid page", 8'h11, xw(va, 2'(k), 2'b00, 1'b0));
        else if (p == 7) expectFault("R10 reserved bit", 8'h12, xw(va, 2'(k), 2'b00, 1'b0));
        else if (p == 9 && k == 1)
          expectFault("R11 page protect", 8'h04, xw(va, 2'(k), 2'b00, 1'b1));
        else expectOk("R6 R10 sweep", 64'h8000_0000 + (64'(p) << 12),
                      {1'b1, (p != 9), 1'b1});
      end
    end
    expectVal("R6 reads per walk", 64'(reqCount) != 0 ? 64'd1 : 64'd0, 64'd1);

    // R9: large frame
    largeEn = 1'b1;
    walk(64'h0013_7123, 2'b00, 2'b00);
    expectOk("R9 large frame", 64'hA37000, 3'b111);
    largeEn = 1'b0;
    walk(64'h0013_7123, 2'b00, 2'b00);
    expectFault("R9 large off", 8'h11, xw(64'h0013_7000, 2'b00, 2'b00, 1'b0));

    // R11: segment protect
    walk(64'h0020_0000, 2'b01, 2'b00);
    expectFault("R11 seg protect store", 8'h04, xw(64'h0020_0000, 2'b01, 2'b00, 1'b1));
    walk(64'h0020_0000, 2'b00, 2'b00);
    expectOk("R11 seg protect read", 64'h7000_0000, 3'b101);

    // R7: invalid and wrong-type segment entries
    walk(64'h0030_0000, 2'b00, 2'b00);
    expectFault("R7 seg invalid", 8'h10, xw(64'h0030_0000, 2'b00, 2'b00, 1'b0));
    walk(64'h0040_0000, 2'b00, 2'b00);
    expectFault("R7 seg type", 8'h12, xw(64'h0040_0000, 2'b00, 2'b00, 1'b0));

    // R5: region-first length
    cr1 = 64'h1000C;
    walk(64'h4000_0000_0000_0000, 2'b00, 2'b00);
    expectFault("R5 first length", 8'h39, xw(64'h4000_0000_0000_0000, 2'b00, 2'b00, 1'b0));
    cr1 = 64'h1000F;

    // R4/R5/R11 with a region-third home designation
    walk(64'h0400_0000_0000, 2'b00, 2'b11);
    expectFault("R4 third high bits", 8'h38, xw(64'h0400_0000_0000, 2'b00, 2'b11, 1'b0));
    walk(64'h0100_0000_0000, 2'b00, 2'b11);
    expectFault("R5 third length", 8'h3B, xw(64'h0100_0000_0000, 2'b00, 2'b11, 1'b0));
    largeEn = 1'b1;
    walk(64'h0, 2'b01, 2'b11);
    expectFault("R11 region protect", 8'h04, xw(64'h0, 2'b01, 2'b11, 1'b1));
    largeEn = 1'b0;
    walk(64'h0, 2'b01, 2'b11);
    expectOk("R11 region protect off", 64'h8000_0000, 3'b111);

    // R8: region entry window (offset 1, length 2)
    walk(64'hA000_0000, 2'b00, 2'b11);
    expectOk("R8 inside window", 64'h8000_0000, 3'b111);
    walk(64'h8000_0000, 2'b00, 2'b11);
    expectFault("R8 below offset", 8'h10, xw(64'h8000_0000, 2'b00, 2'b11, 1'b0));
    walk(64'hE000_0000, 2'b00, 2'b11);
    expectFault("R8 above length", 8'h10, xw(64'hE000_0000, 2'b00, 2'b11, 1'b0));

    // R7/R4: region-second designation
    cr13 = 64'h1000B;
    walk(64'h0, 2'b00, 2'b11);
    expectFault("R7 region type", 8'h12, xw(64'h0, 2'b00, 2'b11, 1'b0));
    walk(64'h0020_0000_0000_0000, 2'b00, 2'b11);
    expectFault("R4 second high bits", 8'h38, xw(64'h0020_0000_0000_0000, 2'b00, 2'b11, 1'b0));
    cr13 = 64'h60004;

    // R2/R12: secondary mode
    walk(64'h2000, 2'b00, 2'b10);
    expectOk("R2 secondary data", 64'h8000_2000, 3'b110);
    walk(64'h2000, 2'b10, 2'b10);
    expectOk("R2 secondary fetch", 64'h8000_2000, 3'b001);
    walk(64'h5000, 2'b00, 2'b10);
    expectFault("R12 secondary data word", 8'h11, xw(64'h5000, 2'b00, 2'b10, 1'b0));
    walk(64'h5000, 2'b10, 2'b10);
    expectFault("R12 secondary fetch word", 8'h11, xw(64'h5000, 2'b10, 2'b00, 1'b0));
    walk(64'h8000_0000, 2'b00, 2'b10);
    expectFault("R4 segment high bits", 8'h38, xw(64'h8000_0000, 2'b00, 2'b10, 1'b0));
    walk(64'h2000_0000, 2'b01, 2'b10);
    expectFault("R5 segment length", 8'h10, xw(64'h2000_0000, 2'b01, 2'b10, 1'b0));
    walk(64'h2000, 2'b00, 2'b01);
    expectOk("R2 mode one as primary", 64'h8000_2000, 3'b111);
    walk(64'h5000, 2'b00, 2'b01);
    expectFault("R12 mode bits", 8'h11, xw(64'h5000, 2'b00, 2'b01, 1'b0));

    // R13: done is a single pulse
    @(negedge clk);
    expectVal("R13 done pulse", {63'b0, done}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule